// File: doc/BRIEF.md
# Packed 128-bit SIMD Integer ALU

This block applies one lane-wise integer operation to two 128-bit vectors and delivers a registered 128-bit result one clock later. A lane-size code splits the vector into sixteen byte lanes, eight halfword lanes or four word lanes. Arithmetic lanes are fully independent: no carry or borrow crosses a lane edge.

Besides add and subtract, the block offers four mask-style operations:

- a test that flags lanes whose operands share a set bit
- an equality compare
- a bitwise select whose mask is the previous destination value
- a full inversion

A broadcast operation copies a 32-bit scalar into every lane. Its lane width comes from two dedicated select inputs rather than from the lane-size code. A pipeline stage feeding a vector register file drives one request per cycle, qualified by a valid strobe. It writes the result back when the output valid appears.

Top module: `simd_alu`

## Requirements
- R1: The lane-size code picks the lane width for add, subtract, test and compare. Code 0 gives sixteen 8-bit lanes, code 1 gives eight 16-bit lanes and code 2 gives four 32-bit lanes. Lane k occupies bits k*W to k*W+W-1.
- R2: Opcode 0 (add) sums the A and B lanes modulo 2^W. No carry passes into the next lane.
- R3: Opcode 1 (subtract) computes A minus B per lane modulo 2^W. No borrow passes between lanes.
- R4: Opcode 2 (test) sets a lane to all ones when the AND of its A and B lanes is nonzero, and to all zeros otherwise.
- R5: Opcode 3 (compare-equal) sets a lane to all ones when its A and B lanes are equal, and to all zeros otherwise.
- R6: Opcode 4 (select) returns (D & A) | (~D & B) over all 128 bits, where D is the old destination input. It ignores the lane-size code.
- R7: Opcode 5 (invert) returns the bitwise complement of A over all 128 bits. It ignores the lane-size code.
- R8: Opcode 6 (broadcast) takes its lane width from the select inputs, with priority in this order:
  - 16 bits when the halfword select is 1
  - otherwise 8 bits when the byte select is 1
  - otherwise 32 bits

  The lane-size code has no effect on this opcode, and code 3 is accepted for it.
- R9: Broadcast keeps the low W bits of the scalar and repeats them in all 128/W lanes.
- R10: An illegal request raises the illegal flag together with the output valid and produces a zero result. Two cases are illegal:
  - lane-size code 3 with opcodes 0 to 3
  - opcode 7 with any lane-size code
- R11: The result, the output valid and the illegal flag update one clock after an input valid. In a cycle with no input valid, the output valid and the illegal flag drop to 0 and the result holds its last value.
- R12: A synchronous active-high reset clears the result, the output valid and the illegal flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe |
| opcode | input | 3 | Operation code (0 add, 1 sub, 2 test, 3 equal, 4 select, 5 invert, 6 broadcast, 7 reserved) |
| laneSize | input | 2 | Lane-size code (0 byte, 1 halfword, 2 word, 3 reserved) |
| dupHalf | input | 1 | Broadcast halfword select |
| dupByte | input | 1 | Broadcast byte select |
| opA | input | 128 | First vector operand |
| opB | input | 128 | Second vector operand |
| oldDst | input | 128 | Previous destination contents, used as the select mask |
| scalar | input | 32 | Scalar source for broadcast |
| result | output | 128 | Registered result vector |
| outValid | output | 1 | Result valid, one clock after inValid |
| illegalOp | output | 1 | Reserved encoding seen, qualified by outValid |

## Verification
Two broadcast width choices can be requested at once: both the halfword and the byte select may be high in the same request. The bench provokes this with a scalar whose low byte and low halfword differ, so the expected halfword replication is distinguishable from the byte one. A second collision is a reserved lane-size code arriving with a broadcast or select opcode. The bench expects a legal result there, while the same code with add must raise the illegal flag. Each case is judged by a scoreboard entry that holds the independently modelled result.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_TST  = 3'd2,
    OP_CEQ  = 3'd3,
    OP_BSL  = 3'd4,
    OP_NOT  = 3'd5,
    OP_DUP  = 3'd6,
    OP_RSVD = 3'd7
  } aluOp_e;

  localparam logic [1:0] LANE_BYTE = 2'd0;
  localparam logic [1:0] LANE_HALF = 2'd1;
  localparam logic [1:0] LANE_WORD = 2'd2;
  localparam logic [1:0] LANE_RSVD = 2'd3;

  // Strobes from control to datapath.
  typedef struct packed {
    logic       load;
    logic       doAdd;
    logic       doSub;
    logic       doTst;
    logic       doCeq;
    logic       doBsl;
    logic       doNot;
    logic       doDup;
    logic       illegal;
    logic [1:0] laneSel;
  } aluCtrl_t;

endpackage

// File: rtl/simd_alu_ctrl.sv
module simd_alu_ctrl
  import simd_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [2:0] opcode,
  input  logic [1:0] laneSize,
  input  logic       dupHalf,
  input  logic       dupByte,
  output aluCtrl_t   ctrl,
  output logic       outValid,
  output logic       illegalOp
);

  logic laneLegal;
  assign laneLegal = (laneSize != LANE_RSVD);

  always_comb begin
    ctrl         = '0;
    ctrl.load    = inValid;
    ctrl.laneSel = laneSize;
    case (opcode)
      OP_ADD: begin ctrl.doAdd = laneLegal; ctrl.illegal = !laneLegal; end
      OP_SUB: begin ctrl.doSub = laneLegal; ctrl.illegal = !laneLegal; end
      OP_TST: begin ctrl.doTst = laneLegal; ctrl.illegal = !laneLegal; end
      OP_CEQ: begin ctrl.doCeq = laneLegal; ctrl.illegal = !laneLegal; end
      OP_BSL: ctrl.doBsl = 1'b1;
      OP_NOT: ctrl.doNot = 1'b1;
      OP_DUP: begin
        ctrl.doDup = 1'b1;
        // halfword select outranks byte select
        if (dupHalf)      ctrl.laneSel = LANE_HALF;
        else if (dupByte) ctrl.laneSel = LANE_BYTE;
        else              ctrl.laneSel = LANE_WORD;
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      outValid  <= inValid;
      illegalOp <= inValid && ctrl.illegal;
    end
  end

  // R10: every accepted request picks exactly one path (an op or illegal)
  p_one_path_r10: assert property (@(posedge clk) disable iff (rst)
    inValid |-> $onehot({ctrl.doAdd, ctrl.doSub, ctrl.doTst, ctrl.doCeq,
                         ctrl.doBsl, ctrl.doNot, ctrl.doDup, ctrl.illegal}));

  p_rsvd_size_r10: assert property (@(posedge clk) disable iff (rst)
    (inValid && laneSize == LANE_RSVD && opcode[2] == 1'b0) |=> illegalOp);

  p_latency_r11: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && !illegalOp));

endmodule

// File: rtl/simd_alu_dp.sv
module simd_alu_dp
  import simd_alu_pkg::*;
#(
  parameter int VEC_W    = 128,
  parameter int SCALAR_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  aluCtrl_t            ctrl,
  input  logic [VEC_W-1:0]    opA,
  input  logic [VEC_W-1:0]    opB,
  input  logic [VEC_W-1:0]    oldDst,
  input  logic [SCALAR_W-1:0] scalar,
  output logic [VEC_W-1:0]    result
);

  localparam int NUM_SIZES = 3;
  localparam int SEL_SLOTS = 4;

  logic [VEC_W-1:0] addV [SEL_SLOTS];
  logic [VEC_W-1:0] subV [SEL_SLOTS];
  logic [VEC_W-1:0] tstV [SEL_SLOTS];
  logic [VEC_W-1:0] ceqV [SEL_SLOTS];
  logic [VEC_W-1:0] dupV [SEL_SLOTS];

  for (genvar gs = 0; gs < NUM_SIZES; gs++) begin : g_size
    localparam int LW = 8 << gs;
    localparam int NL = VEC_W / LW;
    logic [VEC_W-1:0] addS, subS, tstS, ceqS, dupS;
    for (genvar gl = 0; gl < NL; gl++) begin : g_lane
      logic [LW-1:0] la, lb;
      assign la = opA[gl*LW +: LW];
      assign lb = opB[gl*LW +: LW];
      assign addS[gl*LW +: LW] = la + lb;
      assign subS[gl*LW +: LW] = la - lb;
      assign tstS[gl*LW +: LW] = {LW{|(la & lb)}};
      assign ceqS[gl*LW +: LW] = {LW{la == lb}};
      assign dupS[gl*LW +: LW] = scalar[LW-1:0];
    end
    assign addV[gs] = addS;
    assign subV[gs] = subS;
    assign tstV[gs] = tstS;
    assign ceqV[gs] = ceqS;
    assign dupV[gs] = dupS;
  end

  // reserved slot feeds zero; control never selects it for a lane op
  assign addV[SEL_SLOTS-1] = '0;
  assign subV[SEL_SLOTS-1] = '0;
  assign tstV[SEL_SLOTS-1] = '0;
  assign ceqV[SEL_SLOTS-1] = '0;
  assign dupV[SEL_SLOTS-1] = '0;

  logic [VEC_W-1:0] nextRes;

  always_comb begin
    nextRes = '0;
    if (ctrl.doAdd) nextRes = addV[ctrl.laneSel];
    if (ctrl.doSub) nextRes = subV[ctrl.laneSel];
    if (ctrl.doTst) nextRes = tstV[ctrl.laneSel];
    if (ctrl.doCeq) nextRes = ceqV[ctrl.laneSel];
    if (ctrl.doDup) nextRes = dupV[ctrl.laneSel];
    if (ctrl.doBsl) nextRes = (oldDst & opA) | (~oldDst & opB);
    if (ctrl.doNot) nextRes = ~opA;
  end

  always_ff @(posedge clk) begin
    if (rst)            result <= '0;
    else if (ctrl.load) result <= nextRes;
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !ctrl.load |=> $stable(result));

  p_ceq_equal_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrl.load && ctrl.doCeq && opA == opB) |=> (result == {VEC_W{1'b1}}));

  p_not_r7: assert property (@(posedge clk) disable iff (rst)
    (ctrl.load && ctrl.doNot) |=> (result == ~$past(opA)));

  p_illegal_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (ctrl.load && ctrl.illegal) |=> (result == '0));

endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter int VEC_W    = 128,
  parameter int SCALAR_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [2:0]          opcode,
  input  logic [1:0]          laneSize,
  input  logic                dupHalf,
  input  logic                dupByte,
  input  logic [VEC_W-1:0]    opA,
  input  logic [VEC_W-1:0]    opB,
  input  logic [VEC_W-1:0]    oldDst,
  input  logic [SCALAR_W-1:0] scalar,
  output logic [VEC_W-1:0]    result,
  output logic                outValid,
  output logic                illegalOp
);

  aluCtrl_t ctrl;

  simd_alu_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .opcode    (opcode),
    .laneSize  (laneSize),
    .dupHalf   (dupHalf),
    .dupByte   (dupByte),
    .ctrl      (ctrl),
    .outValid  (outValid),
    .illegalOp (illegalOp)
  );

  simd_alu_dp #(
    .VEC_W    (VEC_W),
    .SCALAR_W (SCALAR_W)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .opA    (opA),
    .opB    (opB),
    .oldDst (oldDst),
    .scalar (scalar),
    .result (result)
  );

endmodule

// File: tb/tb_simd_alu.sv
`timescale 1ns/1ps
module tb_simd_alu;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [2:0]   opcode = '0;
  logic [1:0]   laneSize = '0;
  logic         dupHalf = 1'b0;
  logic         dupByte = 1'b0;
  logic [127:0] opA = '0, opB = '0, oldDst = '0;
  logic [31:0]  scalar = '0;
  logic [127:0] result;
  logic         outValid, illegalOp;

  always #2.5 clk = ~clk;

  simd_alu dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opcode(opcode),
    .laneSize(laneSize), .dupHalf(dupHalf), .dupByte(dupByte),
    .opA(opA), .opB(opB), .oldDst(oldDst), .scalar(scalar),
    .result(result), .outValid(outValid), .illegalOp(illegalOp)
  );

  typedef struct {
    logic [127:0] res;
    logic         ill;
    string        tag;
  } expItem_t;

  expItem_t     sbQ[$];
  int           checks = 0;
  int           fails  = 0;
  bit           done   = 0;
  logic [127:0] lastRes = '0;

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] op, input logic [1:0] sz,
      input logic dh, input logic db, input logic [127:0] a,
      input logic [127:0] b, input logic [127:0] d, input logic [31:0] s,
      output logic [127:0] r, output logic ill);
    int w;
    logic [127:0] m, la, lb, rl;
    r = '0; ill = 1'b0;
    if (op <= 3'd3) begin
      if (sz == 2'd3) begin ill = 1'b1; return; end
      w = 8 << sz;
      m = (128'd1 << w) - 128'd1;
      for (int i = 0; i < 128 / w; i++) begin
        la = (a >> (i * w)) & m;
        lb = (b >> (i * w)) & m;
        case (op)
          3'd0: rl = la + lb;
          3'd1: rl = la - lb;
          3'd2: rl = ((la & lb) != 0) ? m : '0;
          default: rl = (la == lb) ? m : '0;
        endcase
        r |= (rl & m) << (i * w);
      end
    end else if (op == 3'd4) r = (d & a) | (~d & b);
    else if (op == 3'd5) r = ~a;
    else if (op == 3'd6) begin
      w = dh ? 16 : (db ? 8 : 32);
      m = (128'd1 << w) - 128'd1;
      for (int i = 0; i < 128 / w; i++) r |= ({96'd0, s} & m) << (i * w);
    end else ill = 1'b1;
  endfunction

  task automatic drive(input logic [2:0] op, input logic [1:0] sz,
      input logic dh, input logic db, input logic [127:0] a,
      input logic [127:0] b, input logic [127:0] d, input logic [31:0] s,
      input string tag);
    expItem_t e;
    @(negedge clk);
    opcode = op; laneSize = sz; dupHalf = dh; dupByte = db;
    opA = a; opB = b; oldDst = d; scalar = s; inValid = 1'b1;
    model(op, sz, dh, db, a, b, d, s, e.res, e.ill);
    e.tag = tag;
    sbQ.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    inValid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // Monitor: pop and compare one scoreboard entry per output valid.
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (sbQ.size() == 0) begin
        check(1'b0, "R11 unexpected outValid", {127'd0, outValid}, 128'd0);
      end else begin
        expItem_t e;
        e = sbQ.pop_front();
        check(result == e.res, e.tag, result, e.res);
        check(illegalOp == e.ill, {e.tag, " illegal flag"},
              {127'd0, illegalOp}, {127'd0, e.ill});
        lastRes = e.res;
      end
    end
  end

  localparam logic [127:0] ALL1 = {128{1'b1}};
  localparam logic [127:0] PAT1 = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
  localparam logic [127:0] PAT2 = 128'hf0f0_0f0f_ffff_0000_1234_5678_9abc_def0;

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check(result == '0 && !outValid && !illegalOp, "R12 reset state",
          result, 128'd0);
    rst = 1'b0;

    // R1 R2: all-ones plus one shows no carry between lanes at each size
    drive(3'd0, 2'd0, 0, 0, ALL1, {16{8'h01}}, '0, '0, "R2 add byte wrap (R1)");
    drive(3'd0, 2'd1, 0, 0, ALL1, {8{16'h0001}}, '0, '0, "R2 add half wrap (R1)");
    drive(3'd0, 2'd2, 0, 0, ALL1, {4{32'h1}}, '0, '0, "R2 add word wrap (R1)");
    drive(3'd0, 2'd1, 0, 0, PAT1, PAT2, '0, '0, "R2 add half pattern");
    // R3: zero minus one wraps per lane
    drive(3'd1, 2'd0, 0, 0, '0, {16{8'h01}}, '0, '0, "R3 sub byte borrow");
    drive(3'd1, 2'd2, 0, 0, '0, {4{32'h1}}, '0, '0, "R3 sub word borrow");
    drive(3'd1, 2'd1, 0, 0, PAT2, PAT1, '0, '0, "R3 sub half pattern");
    // R4
    drive(3'd2, 2'd0, 0, 0, PAT1, PAT2, '0, '0, "R4 test byte");
    drive(3'd2, 2'd2, 0, 0, {32'h1, 32'h0, 32'h8000_0000, 32'h2},
          {32'h1, 32'hffff_ffff, 32'h7fff_ffff, 32'h2}, '0, '0, "R4 test word");
    // R5
    drive(3'd3, 2'd1, 0, 0, PAT1, {PAT1[127:64], PAT2[63:0]}, '0, '0,
          "R5 compare half mixed");
    drive(3'd3, 2'd0, 0, 0, PAT2, PAT2, '0, '0, "R5 compare byte equal");
    // R6: size code 3 is ignored
    drive(3'd4, 2'd3, 0, 0, PAT1, PAT2, {64'hffff_0000_ff00_f0f0, 64'h0}, '0,
          "R6 select with D mask");
    // R7
    drive(3'd5, 2'd3, 0, 0, PAT1, '0, '0, '0, "R7 invert");
    // R8 R9: broadcast widths and priority
    drive(3'd6, 2'd0, 0, 0, '0, '0, '0, 32'hdead_beef, "R8 dup word ignores size");
    drive(3'd6, 2'd2, 0, 1, '0, '0, '0, 32'hdead_beef, "R9 dup byte low bits");
    drive(3'd6, 2'd0, 1, 0, '0, '0, '0, 32'hdead_beef, "R9 dup half low bits");
    drive(3'd6, 2'd3, 1, 1, '0, '0, '0, 32'h1234_5678, "R8 dup half beats byte");
    // R10
    drive(3'd0, 2'd3, 0, 0, PAT1, PAT2, '0, '0, "R10 add reserved size");
    drive(3'd3, 2'd3, 0, 0, PAT1, PAT1, '0, '0, "R10 compare reserved size");
    drive(3'd7, 2'd0, 0, 0, PAT1, PAT2, '0, '0, "R10 reserved opcode");
    drive(3'd5, 2'd0, 0, 0, PAT2, '0, '0, '0, "R11 back-to-back after illegal");

    // R11: idle cycles hold the result and drop the flags
    idle(1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!outValid && !illegalOp, "R11 idle flags low",
            {126'd0, outValid, illegalOp}, 128'd0);
      check(result == lastRes, "R11 result holds when idle", result, lastRes);
    end

    // mixed traffic
    for (int n = 0; n < 60; n++) begin
      drive(3'($urandom % 8), 2'($urandom % 4), 1'($urandom % 2),
            1'($urandom % 2),
            {$urandom, $urandom, $urandom, $urandom},
            ((n % 4) == 0) ? 128'd0 : {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, $urandom,
            "R1 mixed traffic");
    end
    idle(4);
    check(sbQ.size() == 0, "R11 scoreboard drained", 128'(sbQ.size()), 128'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule